// File: doc/BRIEF.md
# Dual-Level Interrupt Mask Controller

This block collects 31 level-sensitive peripheral request lines and sends each of them to one of two processor inputs: a normal interrupt line (`irq_o`) or a fast interrupt line (`fiq_o`). Each level has four registers: raw signal, enable mask, clear mask and masked status. Software reaches them over a small synchronous register bus. Reads return data one cycle after the read strobe.

The enable masks can only be set. A separate write-1-to-clear register clears bits in each mask, so software never needs a read-modify-write to change one source. Hardware also keeps the two masks from overlapping. Setting a source's bit at one level removes the same bit from the other level. This means a source is never enabled at both levels at once.

Bit 0 of every register is reserved for a derived "fast pending" source. It is the OR of the unmasked fast requests. Software can therefore enable fast activity as an ordinary source at the normal level.

Top module: `intmask_ctrl`

## Requirements
- R1: After reset, both enable masks read 0, `irq_o` and `fiq_o` are low, and `bus_rdata` is 0.
- R2: A write to an enable register (normal 0x008, fast 0x108) sets every enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value, so writing 0 never disables a source.
- R3: A write to a clear register (normal 0x00C, fast 0x10C) clears every enable bit of that level whose write-data bit is 1. All other enable bits at both levels keep their value.
- R4: Setting a bit in the fast enable register clears the same bit in the normal enable register. Setting a bit in the normal enable register clears the same bit in the fast enable register.
- R5: No bit is ever 1 in both enable masks at the same time.
- R6: The raw registers (normal 0x004, fast 0x104) return `src_req[n-1]` in bit n for n = 1 to 31. Bit 0 holds the fast-pending value, which is the OR of bits 31..1 of the fast status.
- R7: Each status register (normal 0x000, fast 0x100) reads as its level's raw value ANDed with that level's enable mask.
- R8: `fiq_o` is the OR of bits 31..1 of the fast status. It follows `src_req` with no register stage in between.
- R9: `irq_o` is the OR of all 32 bits of the normal status, including bit 0. A pending fast source therefore raises `irq_o` whenever normal enable bit 0 is set.
- R10: `bus_rdata` is registered. It carries the selected register's value in the cycle after `bus_rd` is high and is 0 otherwise. Reads of the two clear registers and of any unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| src_req | input | 31 | Peripheral request lines; line k maps to register bit k+1 |
| irq_o | output | 1 | Normal interrupt request to the core |
| fiq_o | output | 1 | Fast interrupt request to the core |

## Verification
The assertions assume that `bus_addr`, `bus_wdata` and the strobes are steady around each rising edge. They also assume that at most one write is presented per cycle, which is why the two masks can never receive conflicting set requests in the same cycle. The bench changes every input only at the falling edge and issues a single access per task, so these assumptions always hold. Reset is held low across the first edges, which gives the reset-state property a defined starting point.

// File: rtl/intmask_pkg.sv
// Shared constants and decode helper for the dual-level interrupt mask controller.
// Assumes a 12-bit byte address and word-aligned registers.
package intmask_pkg;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_IRQ_STAT = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_IRQ_RAW  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_IRQ_EN   = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_IRQ_CLR  = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_FIQ_STAT = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_FIQ_RAW  = 12'h104;
    localparam logic [ADDR_W-1:0] OFS_FIQ_EN   = 12'h108;
    localparam logic [ADDR_W-1:0] OFS_FIQ_CLR  = 12'h10C;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_IRQ_STAT,
        SEL_IRQ_RAW,
        SEL_IRQ_EN,
        SEL_IRQ_CLR,
        SEL_FIQ_STAT,
        SEL_FIQ_RAW,
        SEL_FIQ_EN,
        SEL_FIQ_CLR
    } reg_sel_e;

    // Map a byte offset onto a register selector.
    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_IRQ_STAT: s = SEL_IRQ_STAT;
            OFS_IRQ_RAW:  s = SEL_IRQ_RAW;
            OFS_IRQ_EN:   s = SEL_IRQ_EN;
            OFS_IRQ_CLR:  s = SEL_IRQ_CLR;
            OFS_FIQ_STAT: s = SEL_FIQ_STAT;
            OFS_FIQ_RAW:  s = SEL_FIQ_RAW;
            OFS_FIQ_EN:   s = SEL_FIQ_EN;
            OFS_FIQ_CLR:  s = SEL_FIQ_CLR;
            default:      s = SEL_NONE;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/intmask_masks.sv
// Holds the normal and fast enable masks.
// Set writes OR bits in and strip the same bits from the other level.
// Clear writes remove bits from one level only.
// Assumes one access per cycle, so set and clear never collide.
module intmask_masks
    import intmask_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] irq_en,
    output logic [DATA_W-1:0] fiq_en
);
    logic [DATA_W-1:0] irq_nx;
    logic [DATA_W-1:0] fiq_nx;

    // Next-state logic for both masks, including the cross-clear rule.
    always_comb begin
        irq_nx = irq_en;
        fiq_nx = fiq_en;
        if (wr) begin
            case (sel)
                SEL_IRQ_EN: begin
                    irq_nx = irq_en | wdata;
                    fiq_nx = fiq_en & ~wdata;
                end
                SEL_IRQ_CLR: irq_nx = irq_en & ~wdata;
                SEL_FIQ_EN: begin
                    fiq_nx = fiq_en | wdata;
                    irq_nx = irq_en & ~wdata;
                end
                SEL_FIQ_CLR: fiq_nx = fiq_en & ~wdata;
                default: ;
            endcase
        end
    end

    // Mask storage with synchronous reset to all zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en <= '0;
            fiq_en <= '0;
        end else begin
            irq_en <= irq_nx;
            fiq_en <= fiq_nx;
        end
    end
endmodule

// File: rtl/intmask_status.sv
// Builds the raw and masked status words for both levels and the two core outputs.
// Bit 0 of the raw words is the fast-pending value, derived only from bits 31..1.
// This avoids a combinational loop. Purely combinational.
module intmask_status #(
    parameter int DATA_W = 32,
    localparam int SRC_W = DATA_W - 1
) (
    input  logic [SRC_W-1:0]  src_req,
    input  logic [DATA_W-1:0] irq_en,
    input  logic [DATA_W-1:0] fiq_en,
    output logic [DATA_W-1:0] raw_word,
    output logic [DATA_W-1:0] irq_stat,
    output logic [DATA_W-1:0] fiq_stat,
    output logic              irq_o,
    output logic              fiq_o
);
    logic fiq_any;

    // Fast pending: any unmasked fast request among the real sources.
    always_comb fiq_any = |(src_req & fiq_en[DATA_W-1:1]);

    // Raw word shared by both levels.
    always_comb raw_word = {src_req, fiq_any};

    // Per-bit masking for both levels.
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign irq_stat[b] = raw_word[b] & irq_en[b];
        assign fiq_stat[b] = raw_word[b] & fiq_en[b];
    end

    // Core request outputs.
    always_comb begin
        fiq_o = fiq_any;
        irq_o = |irq_stat;
    end
endmodule

// File: rtl/intmask_rdmux.sv
// Registered read-back path. Clear registers and unmapped offsets read as zero.
// Output is zero in cycles that follow no read strobe.
module intmask_rdmux
    import intmask_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] raw_word,
    input  logic [DATA_W-1:0] irq_stat,
    input  logic [DATA_W-1:0] fiq_stat,
    input  logic [DATA_W-1:0] irq_en,
    input  logic [DATA_W-1:0] fiq_en,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] pick;

    // Select the addressed register value.
    always_comb begin
        case (sel)
            SEL_IRQ_STAT: pick = irq_stat;
            SEL_IRQ_RAW:  pick = raw_word;
            SEL_IRQ_EN:   pick = irq_en;
            SEL_FIQ_STAT: pick = fiq_stat;
            SEL_FIQ_RAW:  pick = raw_word;
            SEL_FIQ_EN:   pick = fiq_en;
            default:      pick = '0;
        endcase
    end

    // Capture read data one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd ? pick : '0;
    end
endmodule

// File: rtl/intmask_ctrl.sv
// Top level of the dual-level interrupt mask controller.
// Decodes the register bus, then wires the mask store, the status logic and the read path.
// Assumes a single-port bus with at most one access per cycle.
module intmask_ctrl
    import intmask_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SRC_W = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [SRC_W-1:0]  src_req,
    output logic              irq_o,
    output logic              fiq_o
);
    reg_sel_e          sel;
    logic [DATA_W-1:0] irq_en;
    logic [DATA_W-1:0] fiq_en;
    logic [DATA_W-1:0] raw_word;
    logic [DATA_W-1:0] irq_stat;
    logic [DATA_W-1:0] fiq_stat;

    // Address decode shared by write and read paths.
    always_comb sel = decode_addr(bus_addr);

    intmask_masks #(.DATA_W(DATA_W)) u_masks (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr),
        .sel    (sel),
        .wdata  (bus_wdata),
        .irq_en (irq_en),
        .fiq_en (fiq_en)
    );

    intmask_status #(.DATA_W(DATA_W)) u_status (
        .src_req  (src_req),
        .irq_en   (irq_en),
        .fiq_en   (fiq_en),
        .raw_word (raw_word),
        .irq_stat (irq_stat),
        .fiq_stat (fiq_stat),
        .irq_o    (irq_o),
        .fiq_o    (fiq_o)
    );

    intmask_rdmux #(.DATA_W(DATA_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd       (bus_rd),
        .sel      (sel),
        .raw_word (raw_word),
        .irq_stat (irq_stat),
        .fiq_stat (fiq_stat),
        .irq_en   (irq_en),
        .fiq_en   (fiq_en),
        .rdata    (bus_rdata)
    );
endmodule

// File: rtl/intmask_ctrl_chk.sv
// Property checker for intmask_ctrl, attached by bind.
// Observes bus ports, request lines and the two mask registers.
module intmask_ctrl_chk
    import intmask_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SRC_W = DATA_W - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [SRC_W-1:0]  src_req,
    input logic              fiq_o,
    input logic [DATA_W-1:0] irq_en,
    input logic [DATA_W-1:0] fiq_en
);
    // R1: masks are empty after a reset edge.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (irq_en == '0 && fiq_en == '0 && bus_rdata == '0));

    // R5: the masks never share a set bit.
    p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en & fiq_en) == '0);

    // R2: normal enable write sets every requested bit.
    p_irq_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_IRQ_EN) |=> ((irq_en & $past(bus_wdata)) == $past(bus_wdata)));

    // R3: normal clear write removes every requested bit.
    p_irq_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_IRQ_CLR) |=> ((irq_en & $past(bus_wdata)) == '0));

    // R4: fast enable write strips the same bits from the normal mask.
    p_cross_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_FIQ_EN) |=> ((irq_en & $past(bus_wdata)) == '0));

    // R8: fast output tracks unmasked fast requests.
    p_fiq_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o == |(src_req & fiq_en[DATA_W-1:1]));

    // R10: a read of a clear register or an unmapped offset returns zero.
    p_rd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && decode_addr(bus_addr) inside {SEL_NONE, SEL_IRQ_CLR, SEL_FIQ_CLR})
        |=> bus_rdata == '0);
endmodule

bind intmask_ctrl intmask_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .src_req   (src_req),
    .fiq_o     (fiq_o),
    .irq_en    (irq_en),
    .fiq_en    (fiq_en)
);

// File: tb/intmask_ctrl_test.sv
`timescale 1ns/1ps
module intmask_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [30:0] src_req = '0;
    logic        irq_o;
    logic        fiq_o;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [31:0] m_irq = '0;
    logic [31:0] m_fiq = '0;

    always #4 clk = ~clk;

    intmask_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .src_req(src_req), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Single write; also updates the bench's own mask model.
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        case (a)
            12'h008: begin m_irq = m_irq | d; m_fiq = m_fiq & ~d; end
            12'h00C: m_irq = m_irq & ~d;
            12'h108: begin m_fiq = m_fiq | d; m_irq = m_irq & ~d; end
            12'h10C: m_fiq = m_fiq & ~d;
            default: ;
        endcase
    endtask

    // Single read; data sampled at the falling edge after the capture edge.
    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic check_masks(input string req);
        logic [31:0] ri, rf;
        rd(12'h008, ri);
        rd(12'h108, rf);
        check(req, ri, m_irq);
        check(req, rf, m_fiq);
        check("R5", ri & rf, 32'h0);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R1 rdata", bus_rdata, 32'h0);
        check("R1 irq_o", {31'h0, irq_o}, 32'h0);
        check("R1 fiq_o", {31'h0, fiq_o}, 32'h0);
        rd(12'h008, d); check("R1 irq_en", d, 32'h0);
        rd(12'h108, d); check("R1 fiq_en", d, 32'h0);
    endtask

    task automatic t_set;
        wr(12'h008, 32'h0000_00F0);
        wr(12'h008, 32'h0000_0F00);
        check_masks("R2 set");
        wr(12'h008, 32'h0);
        check_masks("R2 zero write");
        wr(12'h108, 32'h00F0_0000);
        wr(12'h108, 32'h0);
        check_masks("R2 fiq set");
    endtask

    task automatic t_clear;
        logic [31:0] d;
        wr(12'h00C, 32'h0000_0030);
        check_masks("R3 irq clr");
        wr(12'h10C, 32'h0030_0000);
        check_masks("R3 fiq clr");
        rd(12'h00C, d); check("R10 irq clr read", d, 32'h0);
        rd(12'h10C, d); check("R10 fiq clr read", d, 32'h0);
    endtask

    task automatic t_cross;
        wr(12'h108, 32'h0000_0180);
        check_masks("R4 fiq takes");
        wr(12'h008, 32'h0000_0100);
        check_masks("R4 irq takes");
        wr(12'h008, 32'hFFFF_FFFF);
        wr(12'h108, 32'h5555_5555);
        check_masks("R4 full");
    endtask

    // Every source: route to normal, then fast, then clear.
    task automatic t_per_source;
        logic [31:0] d;
        for (int b = 1; b < 32; b++) begin
            wr(12'h00C, 32'hFFFF_FFFF);
            wr(12'h10C, 32'hFFFF_FFFF);
            @(negedge clk);
            src_req = 31'(1) << (b - 1);
            wr(12'h008, 32'(1) << b);
            #1;
            check("R9 irq_o on", {31'h0, irq_o}, 32'h1);
            check("R8 fiq_o off", {31'h0, fiq_o}, 32'h0);
            wr(12'h108, 32'(1) << b);
            #1;
            check("R8 fiq_o on", {31'h0, fiq_o}, 32'h1);
            check("R4 irq_o off", {31'h0, irq_o}, 32'h0);
            rd(12'h104, d);
            check("R6 raw", d, (32'(1) << b) | 32'h1);
            rd(12'h008, d);
            check("R4 irq bit", d, 32'h0);
            wr(12'h10C, 32'(1) << b);
            #1;
            check("R3 fiq_o off", {31'h0, fiq_o}, 32'h0);
        end
        src_req = '0;
    endtask

    task automatic t_pending_bit0;
        logic [31:0] d;
        wr(12'h00C, 32'hFFFF_FFFF);
        wr(12'h10C, 32'hFFFF_FFFF);
        @(negedge clk);
        src_req = 31'(1) << 4;
        wr(12'h108, 32'h0000_0020);
        wr(12'h008, 32'h0000_0001);
        #1;
        check("R9 bit0 irq_o", {31'h0, irq_o}, 32'h1);
        rd(12'h000, d); check("R9 irq status", d, 32'h1);
        rd(12'h100, d); check("R7 fiq status", d, 32'h20);
        rd(12'h004, d); check("R6 irq raw", d, 32'h21);
        src_req = '0;
        #1;
        check("R8 drop", {31'h0, fiq_o}, 32'h0);
        check("R9 drop", {31'h0, irq_o}, 32'h0);
    endtask

    task automatic t_status;
        logic [31:0] d;
        wr(12'h00C, 32'hFFFF_FFFF);
        wr(12'h10C, 32'hFFFF_FFFF);
        @(negedge clk);
        src_req = 31'h5555_5555;
        wr(12'h008, 32'h0000_FFFE);
        wr(12'h108, 32'hFF00_0000);
        rd(12'h000, d); check("R7 irq status", d, 32'hAAAA_AAAB & 32'h0000_FFFE);
        rd(12'h100, d); check("R7 fiq status", d, 32'hAAAA_AAAB & 32'hFF00_0000);
        rd(12'h104, d); check("R6 fiq raw", d, 32'hAAAA_AAAB);
        src_req = '0;
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        rd(12'h010, d); check("R10 unmapped 010", d, 32'h0);
        rd(12'h200, d); check("R10 unmapped 200", d, 32'h0);
        @(negedge clk);
        check("R10 idle", bus_rdata, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_set;
        t_clear;
        t_cross;
        t_per_source;
        t_pending_bit0;
        t_status;
        t_unmapped;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule